// File: doc/BRIEF.md
# Paged DMA Buffer Address Walker

This block turns a transfer descriptor's buffer page list into a stream of physical byte addresses for a USB host data mover. The data buffer may be scattered over up to five independent 4 KB pages. A start pulse captures five 32-bit page pointers, a starting page index and a total byte count. The starting byte offset is taken from the low twelve bits of pointer 0. The walker then offers one beat at a time: an address and a byte count of one to four. The consumer takes a beat by raising `advance`.

A beat never straddles a 4 KB boundary. When the data stream reaches the end of a page, the walker increments its page index and carries on at offset 0 of the next page base. If the stream needs a page beyond the last list entry, the walker flags an overrun and stops. At the end of the transfer it pulses `done`. The final page index and offset stay on the outputs so that the surrounding logic can write them back into the descriptor if it chooses to.

Top module: `pageWalker`

## Requirements
- R1: After reset, `beatValid`, `done` and `overrun` are low and `pageIdx`/`offsetOut` read 0.
- R2: In the cycle after a start pulse with a non-zero count and a start index of 4 or less, the first beat address equals bits 31..12 of the pointer selected by the start index, concatenated with bits 11..0 of pointer 0.
- R3: `beatBytes` equals the smallest of 4, the bytes still to move and the bytes left before the 4 KB boundary. It always lies in the range 1..4.
- R4: After an accepted beat that does not reach the page end, the next beat address is the previous address plus the previous `beatBytes`.
- R5: After an accepted beat that ends exactly on a page end, `pageIdx` rises by one and the next beat starts at offset 0 of that page's base.
- R6: Bits 11..0 of pointers 1 to 4 have no effect on any address produced.
- R7: `done` is high for exactly one cycle, in the cycle after the beat that moves the last byte is accepted. At that time `pageIdx`/`offsetOut` give the position just past the last byte, which is index+1 and offset 0 when the transfer ends on a page end.
- R8: When an accepted beat reaches the end of page 4 with bytes still left, `overrun` rises in the next cycle and no further beat is offered until the next start. A start pulse with an index above 4 and a non-zero count raises `overrun` directly.
- R9: A start pulse with a byte count of 0 gives `done` in the next cycle and offers no beat.
- R10: While `advance` is low, the offered beat holds its address and size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Loads the descriptor fields; ignored while a transfer runs |
| pagePtrs | input | 160 | Five page pointers; pointer i occupies bits 32*i+31..32*i |
| startPage | input | 3 | Starting page index |
| byteCount | input | 16 | Total bytes to move |
| advance | input | 1 | Consumer accepts the offered beat |
| beatValid | output | 1 | A beat is offered |
| beatAddr | output | 32 | Physical byte address of the beat |
| beatBytes | output | 3 | Bytes in the beat, 1..4 |
| done | output | 1 | One-cycle pulse after the last byte |
| overrun | output | 1 | Page list exhausted; held until the next start |
| pageIdx | output | 3 | Current, and after done final, page index |
| offsetOut | output | 12 | Current, and after done final, byte offset |

## Verification
Every result is registered one edge away from its cause. The first beat appears in the cycle after the start edge. Each following beat, together with `done` or `overrun`, appears in the cycle after the edge on which `advance` was sampled high. The bench drives inputs and samples outputs on falling edges. It advances a reference model of page, offset and remaining bytes only when it has driven `advance` high, and it compares the design against that model at the next falling edge. When it holds `advance` low, the model stays unchanged, so the same falling-edge comparison checks that the offered beat holds.

// File: rtl/pw_pkg.sv
package pw_pkg;
  typedef struct packed {
    logic load;
    logic step;
  } pwCtrl_t;
endpackage

// File: rtl/pwDatapath.sv
module pwDatapath
  import pw_pkg::*;
#(
  parameter int NUM_PAGES = 5,
  parameter int IDX_W     = 3,
  parameter int CNT_W     = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  pwCtrl_t                ctrl,
  input  logic [NUM_PAGES*32-1:0] pagePtrs,
  input  logic [IDX_W-1:0]       startPage,
  input  logic [CNT_W-1:0]       byteCount,
  output logic [31:0]            beatAddr,
  output logic [2:0]             beatBytes,
  output logic                   lastBeat,
  output logic                   overrunNext,
  output logic                   startBad,
  output logic                   zeroCount,
  output logic [IDX_W-1:0]       pageIdx,
  output logic [11:0]            offsetOut
);
  localparam int PAGE_BYTES = 4096;
  localparam int OFF_W      = 12;
  localparam int BASE_W     = 32 - OFF_W;

  logic [BASE_W-1:0] bases [NUM_PAGES];
  logic [IDX_W-1:0]  page;
  logic [OFF_W-1:0]  offset;
  logic [CNT_W-1:0]  remain;
  logic [OFF_W:0]    toBound;
  logic [2:0]        size;
  logic              crossing;
  logic [BASE_W-1:0] curBase;

  // Only the page base field of each pointer is kept; reserved low bits are dropped.
  for (genvar i = 0; i < NUM_PAGES; i++) begin : gBase
    always_ff @(posedge clk) begin
      if (!rstN)          bases[i] <= '0;
      else if (ctrl.load) bases[i] <= pagePtrs[i*32+OFF_W +: BASE_W];
    end
  end

  always_comb begin
    toBound = (OFF_W+1)'(PAGE_BYTES) - {1'b0, offset};
    size    = 3'd4;
    if (remain < CNT_W'(4))             size = remain[2:0];
    if (toBound < (OFF_W+1)'(size))     size = toBound[2:0];
    crossing = ((OFF_W+1)'(size) == toBound);
    curBase  = '0;
    for (int k = 0; k < NUM_PAGES; k++)
      if (page == IDX_W'(k)) curBase = bases[k];
  end

  assign beatAddr    = {curBase, offset};
  assign beatBytes   = size;
  assign lastBeat    = (CNT_W'(size) == remain);
  assign overrunNext = crossing && !lastBeat && (page >= IDX_W'(NUM_PAGES - 1));
  assign zeroCount   = (byteCount == '0);
  assign startBad    = (startPage >= IDX_W'(NUM_PAGES)) && !zeroCount;
  assign pageIdx     = page;
  assign offsetOut   = offset;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      page   <= '0;
      offset <= '0;
      remain <= '0;
    end else if (ctrl.load) begin
      page   <= startPage;
      offset <= pagePtrs[OFF_W-1:0];
      remain <= byteCount;
    end else if (ctrl.step) begin
      remain <= remain - CNT_W'(size);
      if (crossing) begin
        offset <= '0;
        page   <= page + 1'b1;
      end else begin
        offset <= offset + OFF_W'(size);
      end
    end
  end
endmodule

// File: rtl/pwControl.sv
module pwControl
  import pw_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    advance,
  input  logic    lastBeat,
  input  logic    overrunNext,
  input  logic    startBad,
  input  logic    zeroCount,
  output pwCtrl_t ctrl,
  output logic    beatValid,
  output logic    done,
  output logic    overrun
);
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_ERR} pwState_e;
  pwState_e state;

  assign ctrl.load = start && (state != ST_RUN);
  assign ctrl.step = (state == ST_RUN) && advance;
  assign beatValid = (state == ST_RUN);
  assign overrun   = (state == ST_ERR);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (ctrl.load) begin
        if (zeroCount) begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end else if (startBad) begin
          state <= ST_ERR;
        end else begin
          state <= ST_RUN;
        end
      end else if (ctrl.step) begin
        if (lastBeat) begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end else if (overrunNext) begin
          state <= ST_ERR;
        end
      end
    end
  end
endmodule

// File: rtl/pageWalker.sv
module pageWalker
  import pw_pkg::*;
#(
  parameter int NUM_PAGES = 5,
  parameter int IDX_W     = 3,
  parameter int CNT_W     = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic [NUM_PAGES*32-1:0] pagePtrs,
  input  logic [IDX_W-1:0]        startPage,
  input  logic [CNT_W-1:0]        byteCount,
  input  logic                    advance,
  output logic                    beatValid,
  output logic [31:0]             beatAddr,
  output logic [2:0]              beatBytes,
  output logic                    done,
  output logic                    overrun,
  output logic [IDX_W-1:0]        pageIdx,
  output logic [11:0]             offsetOut
);
  pwCtrl_t ctrl;
  logic lastBeat, overrunNext, startBad, zeroCount;

  pwControl uCtrl (
    .clk, .rstN, .start, .advance, .lastBeat, .overrunNext, .startBad,
    .zeroCount, .ctrl, .beatValid, .done, .overrun
  );

  pwDatapath #(.NUM_PAGES(NUM_PAGES), .IDX_W(IDX_W), .CNT_W(CNT_W)) uData (
    .clk, .rstN, .ctrl, .pagePtrs, .startPage, .byteCount, .beatAddr,
    .beatBytes, .lastBeat, .overrunNext, .startBad, .zeroCount, .pageIdx,
    .offsetOut
  );
endmodule

// File: rtl/pageWalker_checker.sv
module pageWalker_checker #(
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             advance,
  input logic             beatValid,
  input logic [31:0]      beatAddr,
  input logic [2:0]       beatBytes,
  input logic             done,
  input logic             overrun,
  input logic [IDX_W-1:0] pageIdx
);
  assert_beat_size_R3: assert property (@(posedge clk) disable iff (!rstN)
    beatValid |-> (beatBytes >= 3'd1) && (beatBytes <= 3'd4) &&
                  (({1'b0, beatAddr[11:0]} + 13'(beatBytes)) <= 13'd4096));

  assert_addr_advance_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(beatValid && advance) && beatValid && (beatAddr[11:0] != 12'd0))
      |-> (beatAddr == $past(beatAddr) + 32'($past(beatBytes))));

  assert_page_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(beatValid && advance) && beatValid && (beatAddr[11:0] == 12'd0))
      |-> (pageIdx == $past(pageIdx) + 1'b1));

  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (beatValid && !advance) |=> beatValid && $stable(beatAddr) && $stable(beatBytes));

  assert_overrun_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    overrun |-> !beatValid);

  assert_done_clean_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !beatValid && !overrun);
endmodule

bind pageWalker pageWalker_checker #(.IDX_W(IDX_W)) uChecker (
  .clk, .rstN, .advance, .beatValid, .beatAddr, .beatBytes, .done, .overrun,
  .pageIdx
);

// File: tb/pageWalker_test.sv
module pageWalker_test;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [159:0] pagePtrs = '0;
  logic [2:0]   startPage = '0;
  logic [15:0]  byteCount = '0;
  logic         advance = 1'b0;
  logic         beatValid, done, overrun;
  logic [31:0]  beatAddr;
  logic [2:0]   beatBytes;
  logic [2:0]   pageIdx;
  logic [11:0]  offsetOut;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  pageWalker uut (
    .clk, .rstN, .start, .pagePtrs, .startPage, .byteCount, .advance,
    .beatValid, .beatAddr, .beatBytes, .done, .overrun, .pageIdx, .offsetOut
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [2:0] expSize(input int off, input int rem);
    int s = 4;
    if (rem < s) s = rem;
    if (4096 - off < s) s = 4096 - off;
    return 3'(s);
  endfunction

  // Runs one transfer and compares every cycle against a reference model.
  task automatic runXfer(input logic [31:0] p0, input logic [31:0] p1,
                         input logic [31:0] p2, input logic [31:0] p3,
                         input logic [31:0] p4, input int sp, input int cnt,
                         input int advPct, input string tag);
    logic [31:0] ptr [5];
    int mPage, mOff, mRem, sz, guard;
    bit first;
    ptr[0] = p0; ptr[1] = p1; ptr[2] = p2; ptr[3] = p3; ptr[4] = p4;
    @(negedge clk);
    pagePtrs  = {p4, p3, p2, p1, p0};
    startPage = 3'(sp);
    byteCount = 16'(cnt);
    start     = 1'b1;
    @(negedge clk);
    start = 1'b0;
    mPage = sp; mOff = int'(p0[11:0]); mRem = cnt;
    if (cnt == 0) begin
      chk(done == 1'b1, "R9", {tag, " done for zero count"}, 32'(done), 1);
      chk(beatValid == 1'b0, "R9", {tag, " no beat for zero count"}, 32'(beatValid), 0);
      @(negedge clk);
      chk(done == 1'b0, "R7", {tag, " done lasts one cycle"}, 32'(done), 0);
      return;
    end
    if (sp > 4) begin
      chk(overrun == 1'b1, "R8", {tag, " overrun on bad start index"}, 32'(overrun), 1);
      chk(beatValid == 1'b0, "R8", {tag, " no beat on bad index"}, 32'(beatValid), 0);
      return;
    end
    first = 1'b1;
    guard = 0;
    while (guard < 20000) begin
      guard++;
      if (mRem == 0) begin
        chk(done == 1'b1, "R7", {tag, " done after last byte"}, 32'(done), 1);
        chk(pageIdx == 3'(mPage), "R7", {tag, " final page"}, 32'(pageIdx), 32'(mPage));
        chk(offsetOut == 12'(mOff), "R7", {tag, " final offset"}, 32'(offsetOut), 32'(mOff));
        @(negedge clk);
        chk(done == 1'b0, "R7", {tag, " done lasts one cycle"}, 32'(done), 0);
        return;
      end
      if (mPage > 4) begin
        chk(overrun == 1'b1, "R8", {tag, " overrun after page 4"}, 32'(overrun), 1);
        chk(beatValid == 1'b0, "R8", {tag, " no beat after overrun"}, 32'(beatValid), 0);
        @(negedge clk);
        chk(overrun == 1'b1 && beatValid == 1'b0, "R8", {tag, " overrun held"}, 32'(overrun), 1);
        return;
      end
      sz = int'(expSize(mOff, mRem));
      chk(beatValid == 1'b1, first ? "R2" : "R4", {tag, " beat offered"}, 32'(beatValid), 1);
      chk(beatAddr == {ptr[mPage][31:12], 12'(mOff)},
          first ? "R2" : (mOff == 0 ? "R5" : "R4"), {tag, " address (R6 R10)"},
          beatAddr, {ptr[mPage][31:12], 12'(mOff)});
      chk(beatBytes == 3'(sz), "R3", {tag, " beat size"}, 32'(beatBytes), 32'(sz));
      first = 1'b0;
      advance = (($urandom % 100) < advPct);
      @(negedge clk);
      if (advance) begin
        mRem -= sz;
        mOff += sz;
        if (mOff == 4096) begin
          mOff = 0;
          mPage++;
        end
      end
      advance = 1'b0;
    end
    chk(1'b0, "R7", {tag, " transfer never ended"}, 32'(guard), 0);
  endtask

  function automatic logic [31:0] rndPtr(input bit keepLow);
    logic [31:0] v = $urandom;
    if (!keepLow) v[11:0] = 12'hABC ^ 12'($urandom);
    return v;
  endfunction

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    chk(beatValid == 1'b0 && done == 1'b0 && overrun == 1'b0, "R1",
        "outputs idle in reset", {29'b0, beatValid, done, overrun}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(pageIdx == 3'd0 && offsetOut == 12'd0, "R1", "position cleared",
        {17'b0, pageIdx, offsetOut}, 0);

    // Directed corner cases.
    runXfer(32'h1000_0FFE, 32'h2000_1FFF, 32'h3000_2FFF, 32'h4000_3FFF,
            32'h5000_4FFF, 0, 10, 100, "split at boundary R5 R6");
    runXfer(32'h1111_1FF0, 32'h2222_2123, 32'h3333_3456, 32'h4444_4789,
            32'h5555_5ABC, 1, 16, 60, "end on boundary R7");
    runXfer(32'hAAAA_AF00, 32'h0, 32'h0, 32'h0,
            32'hBBBB_BFFF, 4, 300, 80, "overrun R8");
    runXfer(32'h0000_0010, 32'h0, 32'h0, 32'h0, 32'h0, 5, 5, 100, "bad index R8");
    runXfer(32'h0000_0010, 32'h0, 32'h0, 32'h0, 32'h0, 2, 0, 100, "zero count R9");
    runXfer(32'h8000_0003, 32'h9000_0FFF, 32'h0, 32'h0, 32'h0, 0, 3, 20, "short stall R10");

    // Constrained random transfers.
    for (int n = 0; n < 40; n++) begin
      runXfer(rndPtr(1'b1), rndPtr(1'b0), rndPtr(1'b0), rndPtr(1'b0), rndPtr(1'b0),
              int'($urandom % 5), int'($urandom % 400), 50 + int'($urandom % 51),
              "random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule